// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY out of reset and confirms that its receive PLL has locked. It has no access to the PHY registers itself. It drives a command port that an external control-register handshake master executes. The port carries one start pulse with an operation code for address, write or read, and it returns done, error and read data. A single `start_i` pulse launches the whole sequence. When it ends, the block raises a one-cycle `done_o` together with a status code.

The sequence has three parts. An optional pre-step first releases an external power-down line and then pulses an active-low software-reset line. The block then selects the PHY clock/reset register and writes its reset bit. This write is issued without waiting for an acknowledge, because a PHY that is resetting cannot answer. Next comes a bounded polling loop. Each pass waits a settle interval, selects the lane output-status register, reads it and tests the receive-PLL-state bit. The settle interval, the poll bound, the reset-pulse width and the presence of the pre-step are all parameters.

Top module: `phy_lock_seq`

## Requirements
- R1: A `start_i` pulse in idle leads, after the optional pre-step, to an address command (`cmd_op`=0) carrying 16'h7F3F. The block waits for that command's done before it goes on.
- R2: The cycle after that address completes, a write command (`cmd_op`=1) carrying 16'h0001 is started for exactly one cycle. The block does not wait for its done or error. Any acknowledge that arrives for it is ignored.
- R3: Each poll's address command is started exactly SETTLE_CYC+1 cycles after the start of the reset write, or after the cycle in which the previous read's done was high.
- R4: A poll is an address command carrying 16'h2003 followed by a read command (`cmd_op`=2). If bit 1 of `cmd_rdata` is 1 in the read's done cycle, `done_o` rises the next cycle with `status_o`=0 (locked).
- R5: At most POLL_MAX polls are made. If the POLL_MAX-th read shows bit 1 clear, `done_o` rises the next cycle with `status_o`=1 (timeout), and no further command is started.
- R6: An error on any awaited address or read command ends the sequence. `done_o` rises the next cycle with `status_o`=2 (command error), and no further command is started.
- R7: `done_o` is a single-cycle pulse, and there is exactly one per accepted start. `cmd_start` never stays high for two cycles in a row.
- R8: With EXT_RST=1, `pwr_down_o` is 1 out of reset and falls one cycle after start is accepted. `sw_rst_n_o` falls in the following cycle and stays low for PULSE_CYC cycles. It rises in the same cycle that the 16'h7F3F address command starts.
- R9: A `start_i` pulse while a sequence is running is ignored. The command stream and the single result are unchanged.
- R10: After reset, `done_o` and `cmd_start` are 0, `sw_rst_n_o` is 1 and `pwr_down_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch the sequence (honoured in idle only) |
| cmd_start | output | 1 | One-cycle command request to the handshake master |
| cmd_op | output | 2 | Operation: 0 address, 1 write, 2 read |
| cmd_wdata | output | 16 | Register address or write data for the command |
| cmd_done | input | 1 | Command completed |
| cmd_err | input | 1 | Command failed |
| cmd_rdata | input | 16 | Read data, valid with `cmd_done` of a read |
| pwr_down_o | output | 1 | External power-down line (pre-step) |
| sw_rst_n_o | output | 1 | External active-low software reset (pre-step) |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| status_o | output | 2 | 0 locked, 1 timeout, 2 command error; valid with `done_o` |

## Verification
All timing is counted from the cycle in which a stimulus is high. The done pulse is due one cycle after the cycle holding the final read done or the error. A status-register address is due SETTLE_CYC+1 cycles after the reset-write start or the preceding read done. The power-down release is due one cycle after start, and the reset-register address is due PULSE_CYC+2 cycles after start. The scoreboard stamps each acknowledge, write start and start pulse with a free-running cycle count, and it samples every port on the falling edge. Each expected command and result is compared against those stamps at the exact cycle the rule names.

// File: rtl/plt_pkg.sv
package plt_pkg;
  localparam int CR_W = 16;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_LOCKED  = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_CMD_ERR = 2'd2
  } seq_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PD_CLR,
    S_RST_LO,
    S_ADDR_RST,
    S_WR_RST,
    S_SETTLE,
    S_ADDR_STAT,
    S_READ_STAT
  } seq_state_e;

  localparam logic [CR_W-1:0] REG_CLK_RESET = 16'h7F3F;
  localparam logic [CR_W-1:0] RESET_VALUE   = 16'h0001;
  localparam logic [CR_W-1:0] REG_LANE_STAT = 16'h2003;
  localparam int              PLL_LOCK_BIT  = 1;

  function automatic logic pll_locked(input logic [CR_W-1:0] stat);
    return stat[PLL_LOCK_BIT];
  endfunction

  // true when the read that just finished is the last one allowed
  function automatic logic poll_exhausted(input logic [31:0] done_polls,
                                          input logic [31:0] limit);
    return (done_polls + 32'd1) >= limit;
  endfunction
endpackage

// File: rtl/plt_down_timer.sv
module plt_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));

  AST_TICK_NEEDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt != '0)); // R3
endmodule

// File: rtl/plt_cmd_port.sv
module plt_cmd_port (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic no_wait,
  input  logic cmd_done,
  input  logic cmd_err,
  output logic start,
  output logic ok,
  output logic fail
);
  logic pending;

  assign start = req & ~pending;
  assign ok    = pending & cmd_done & ~cmd_err;
  assign fail  = pending & cmd_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pending <= 1'b0;
    else if (start && !no_wait)          pending <= 1'b1;
    else if (pending && (cmd_done || cmd_err)) pending <= 1'b0;
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R7
endmodule

// File: rtl/phy_lock_seq.sv
module phy_lock_seq #(
  parameter int SETTLE_CYC = 8,
  parameter int POLL_MAX   = 4,
  parameter int PULSE_CYC  = 3,
  parameter bit EXT_RST    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        cmd_start,
  output logic [1:0]  cmd_op,
  output logic [15:0] cmd_wdata,
  input  logic        cmd_done,
  input  logic        cmd_err,
  input  logic [15:0] cmd_rdata,
  output logic        pwr_down_o,
  output logic        sw_rst_n_o,
  output logic        done_o,
  output logic [1:0]  status_o
);
  import plt_pkg::*;

  localparam int TMAX = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLL_MAX + 1);

  seq_state_e       state, nxt;
  logic [PW-1:0]    poll_cnt;
  logic             req, no_wait, cp_ok, cp_fail;
  cmd_op_e          op;
  logic [CR_W-1:0]  wdata;
  logic             tmr_load, tmr_tick, tmr_last;
  logic [TW-1:0]    tmr_val;
  logic             fin, poll_inc, poll_clr;
  seq_status_e      fin_code;
  logic             pd_clr, rst_lo, rst_hi;

  plt_cmd_port u_port (
    .clk(clk), .rst_n(rst_n), .req(req), .no_wait(no_wait),
    .cmd_done(cmd_done), .cmd_err(cmd_err),
    .start(cmd_start), .ok(cp_ok), .fail(cp_fail)
  );

  assign tmr_tick = (state == S_RST_LO) || (state == S_SETTLE);

  plt_down_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .tick(tmr_tick), .last(tmr_last)
  );

  assign cmd_op    = op;
  assign cmd_wdata = wdata;

  always_comb begin
    nxt      = state;
    req      = 1'b0;
    no_wait  = 1'b0;
    op       = OP_ADDR;
    wdata    = '0;
    tmr_load = 1'b0;
    tmr_val  = TW'(SETTLE_CYC);
    fin      = 1'b0;
    fin_code = ST_LOCKED;
    poll_inc = 1'b0;
    poll_clr = 1'b0;
    pd_clr   = 1'b0;
    rst_lo   = 1'b0;
    rst_hi   = 1'b0;
    case (state)
      S_IDLE: if (start_i) begin
        poll_clr = 1'b1;
        if (EXT_RST) begin pd_clr = 1'b1; nxt = S_PD_CLR; end
        else nxt = S_ADDR_RST;
      end
      S_PD_CLR: begin
        rst_lo   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TW'(PULSE_CYC);
        nxt      = S_RST_LO;
      end
      S_RST_LO: if (tmr_last) begin rst_hi = 1'b1; nxt = S_ADDR_RST; end
      S_ADDR_RST: begin
        req   = 1'b1;
        wdata = REG_CLK_RESET;
        if (cp_fail)    begin fin = 1'b1; fin_code = ST_CMD_ERR; end
        else if (cp_ok) nxt = S_WR_RST;
      end
      S_WR_RST: begin
        req      = 1'b1;
        no_wait  = 1'b1;
        op       = OP_WRITE;
        wdata    = RESET_VALUE;
        tmr_load = 1'b1;
        nxt      = S_SETTLE;
      end
      S_SETTLE: if (tmr_last) nxt = S_ADDR_STAT;
      S_ADDR_STAT: begin
        req   = 1'b1;
        wdata = REG_LANE_STAT;
        if (cp_fail)    begin fin = 1'b1; fin_code = ST_CMD_ERR; end
        else if (cp_ok) nxt = S_READ_STAT;
      end
      S_READ_STAT: begin
        req = 1'b1;
        op  = OP_READ;
        if (cp_fail) begin
          fin = 1'b1; fin_code = ST_CMD_ERR;
        end else if (cp_ok) begin
          if (pll_locked(cmd_rdata)) begin
            fin = 1'b1; fin_code = ST_LOCKED;
          end else if (poll_exhausted(32'(poll_cnt), 32'(POLL_MAX))) begin
            fin = 1'b1; fin_code = ST_TIMEOUT;
          end else begin
            poll_inc = 1'b1;
            tmr_load = 1'b1;
            nxt      = S_SETTLE;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
    if (fin) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      poll_cnt <= '0;
      done_o   <= 1'b0;
      status_o <= ST_LOCKED;
    end else begin
      state  <= nxt;
      done_o <= fin;
      if (fin)           status_o <= fin_code;
      if (poll_clr)      poll_cnt <= '0;
      else if (poll_inc) poll_cnt <= poll_cnt + 1'b1;
    end
  end

  generate
    if (EXT_RST) begin : g_ext
      logic pd_q, rst_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pd_q  <= 1'b1;
          rst_q <= 1'b1;
        end else begin
          if (pd_clr) pd_q <= 1'b0;
          if (rst_lo)      rst_q <= 1'b0;
          else if (rst_hi) rst_q <= 1'b1;
        end
      end
      assign pwr_down_o = pd_q;
      assign sw_rst_n_o = rst_q;

      AST_PD_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_rst_n_o) |-> !pwr_down_o); // R8
    end else begin : g_noext
      assign pwr_down_o = 1'b0;
      assign sw_rst_n_o = 1'b1;
    end
  endgenerate

  AST_RST_WRITE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == OP_WRITE) |-> cmd_wdata == RESET_VALUE); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cp_fail |=> (done_o && status_o == ST_CMD_ERR)); // R6
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt < PW'(POLL_MAX)); // R5
  AST_LOCK_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_READ_STAT && cp_ok && cmd_rdata[PLL_LOCK_BIT])
      |=> (done_o && status_o == ST_LOCKED)); // R4
endmodule

// File: tb/phy_lock_seq_bench.sv
module phy_lock_seq_bench;
  localparam int SETTLE = 8;
  localparam int POLLS  = 4;
  localparam int PULSE  = 3;
  localparam int LAT    = 2;

  typedef struct {
    logic [1:0]  op;
    logic [15:0] data;
  } exp_cmd_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cmd_start;
  logic [1:0]  cmd_op;
  logic [15:0] cmd_wdata;
  logic        cmd_done = 1'b0;
  logic        cmd_err = 1'b0;
  logic [15:0] cmd_rdata = 16'h0;
  logic        pwr_down_o, sw_rst_n_o, done_o;
  logic [1:0]  status_o;

  always #2 clk = ~clk;

  phy_lock_seq #(.SETTLE_CYC(SETTLE), .POLL_MAX(POLLS), .PULSE_CYC(PULSE),
                 .EXT_RST(1'b1)) u_phy_lock_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_done(cmd_done), .cmd_err(cmd_err), .cmd_rdata(cmd_rdata),
    .pwr_down_o(pwr_down_o), .sw_rst_n_o(sw_rst_n_o),
    .done_o(done_o), .status_o(status_o)
  );

  int checks = 0, errors = 0;
  int cyc = 0;
  exp_cmd_t    cmd_q[$];
  logic [1:0]  stat_q[$];
  exp_cmd_t    e;
  logic [1:0]  es;
  int lock_k = 0, err_k = 0, resp_n = 0, read_n = 0, cnt = 0;
  logic [1:0] pend_op = 2'd0;
  int last_ev = 0, last_resp = 0, start_cyc = 0, low_start = 0;
  int done_seen = 0, extra = 0;
  logic prev_rst = 1'b1, prev_pd = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] s);
    if (s == 2'd0) return "R4";
    if (s == 2'd1) return "R5";
    return "R6";
  endfunction

  // master model and scoreboard monitor
  always @(negedge clk) begin
    cmd_done = 1'b0;
    cmd_err  = 1'b0;
    if (rst_n) begin
      if (done_o) begin
        done_seen++;
        if (stat_q.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
        else begin
          es = stat_q.pop_front();
          chk(status_o == es, req_of(es), "status", status_o, es);
          chk(cyc == last_resp + 1, "R7", "done cycle", cyc - last_resp, 1);
        end
      end
      if (cnt == 1) begin
        resp_n++;
        last_resp = cyc;
        if (resp_n == err_k) cmd_err = 1'b1;
        else begin
          cmd_done = 1'b1;
          if (pend_op == 2'd2) begin
            read_n++;
            cmd_rdata = (read_n == lock_k) ? 16'h0002 : 16'hFFFD;
            last_ev = cyc;
          end
        end
      end
      if (cnt != 0) cnt--;
      if (cmd_start) begin
        if (cmd_q.size() == 0) begin
          extra++;
          chk(0, "R5", "command after end", cmd_op, 3);
        end else begin
          e = cmd_q.pop_front();
          chk(cmd_op == e.op, "R1", "command op", cmd_op, e.op);
          if (e.op != 2'd2)
            chk(cmd_wdata == e.data, "R1", "command data", cmd_wdata, e.data);
          if (e.op == 2'd0 && e.data == 16'h2003)
            chk(cyc == last_ev + SETTLE + 1, "R3", "settle gap",
                cyc - last_ev, SETTLE + 1);
          if (e.op == 2'd0 && e.data == 16'h7F3F) begin
            chk(sw_rst_n_o == 1'b1, "R8", "reset line high at address", sw_rst_n_o, 1);
            chk(cyc == start_cyc + 2 + PULSE, "R8", "first address cycle",
                cyc - start_cyc, 2 + PULSE);
          end
        end
        if (cmd_op == 2'd1) last_ev = cyc;
        else begin
          cnt = LAT;
          pend_op = cmd_op;
        end
      end
      if (prev_pd && !pwr_down_o)
        chk(cyc == start_cyc + 1, "R8", "power-down release cycle", cyc - start_cyc, 1);
      if (prev_rst && !sw_rst_n_o) begin
        low_start = cyc;
        chk(!pwr_down_o, "R8", "power-down clear before reset", pwr_down_o, 0);
        chk(cyc == start_cyc + 2, "R8", "reset low cycle", cyc - start_cyc, 2);
      end
      if (!prev_rst && sw_rst_n_o)
        chk(cyc - low_start == PULSE, "R8", "reset low width", cyc - low_start, PULSE);
      prev_rst = sw_rst_n_o;
      prev_pd  = pwr_down_o;
    end
  end

  task automatic run_case(input int lk, input int ek, input bit poke);
    int n;
    bit fin;
    int d0;
    int w;
    exp_cmd_t c;
    n = 0;
    fin = 0;
    c.op = 2'd0; c.data = 16'h7F3F; cmd_q.push_back(c); n++;
    if (n == ek) begin stat_q.push_back(2'd2); fin = 1; end
    if (!fin) begin
      c.op = 2'd1; c.data = 16'h0001; cmd_q.push_back(c);
      for (int p = 1; p <= POLLS && !fin; p++) begin
        c.op = 2'd0; c.data = 16'h2003; cmd_q.push_back(c); n++;
        if (n == ek) begin stat_q.push_back(2'd2); fin = 1; end
        if (!fin) begin
          c.op = 2'd2; c.data = 16'h0; cmd_q.push_back(c); n++;
          if (n == ek) begin stat_q.push_back(2'd2); fin = 1; end
          else if (p == lk) begin stat_q.push_back(2'd0); fin = 1; end
          else if (p == POLLS) begin stat_q.push_back(2'd1); fin = 1; end
        end
      end
    end
    @(negedge clk);
    lock_k = lk; err_k = ek; resp_n = 0; read_n = 0; extra = 0;
    d0 = done_seen;
    start_i = 1'b1;
    start_cyc = cyc;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      start_i = 1'b1;   // R9: ignored while busy
      @(negedge clk);
      start_i = 1'b0;
    end
    w = 0;
    while (done_seen == d0 && w < 2000) begin
      @(negedge clk);
      w++;
    end
    repeat (30) @(negedge clk);
    chk(done_seen == d0 + 1, poke ? "R9" : "R7", "done pulses per start",
        done_seen - d0, 1);
    chk(cmd_q.size() == 0, "R1", "expected commands left", cmd_q.size(), 0);
    chk(extra == 0, ek != 0 ? "R6" : "R5", "commands after result", extra, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done_o == 1'b0, "R10", "reset done", done_o, 0);
    chk(cmd_start == 1'b0, "R10", "reset cmd_start", cmd_start, 0);
    chk(pwr_down_o == 1'b1, "R10", "reset power-down", pwr_down_o, 1);
    chk(sw_rst_n_o == 1'b1, "R10", "reset sw reset", sw_rst_n_o, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(pwr_down_o == 1'b1, "R10", "idle power-down", pwr_down_o, 1);
    run_case(1, 0, 0);      // R4 lock on first poll
    run_case(3, 0, 0);      // R4 lock on third poll
    run_case(POLLS, 0, 0);  // R5 lock on the last allowed poll
    run_case(0, 0, 0);      // R5 timeout
    run_case(0, 1, 0);      // R6 error on reset-register address
    run_case(0, 4, 0);      // R6 error on second poll address
    run_case(0, 5, 0);      // R6 error on second poll read
    run_case(2, 0, 1);      // R9 start while busy
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not end actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule